// File: doc/BRIEF.md
# Oversampling Fractional Baud Tick Generator

This block makes the timing ticks for a serial receiver and transmitter that sample each bit sixteen times. It divides a fast source clock in two stages. The first stage is an integer prescaler with a fractional stretch. It emits a sample tick every `presc` source clocks. A 4-bit code picks which of the sixteen sample periods in a bit last one source clock longer. The second stage counts sample ticks into bits. An 8-bit per-bit pattern can give any bit of a character one extra sample period.

The start-bit detector pulses `restart` to line the timing up with the incoming edge. Every slot and bit counter then begins again from zero. Around the middle of each bit, three strobes mark sample slots 7, 8 and 9. A registered 2-of-3 vote of the serial input at those strobes gives the sampled bit value.

Top module: `ovs_baud_gen`

## Requirements
- R1: After reset, with `enable` low, `samp_tick`, `bit_tick`, `vote_stb` and `vote_bit` are all 0.
- R2: When `presc` is 0 or 1, the first stage is bypassed and `samp_tick` is high on every running source clock that is not a restart cycle, whatever the value of `fmod`.
- R3: When `presc` is 2 or more, an unstretched sample slot lasts exactly `presc` source clocks. Slot 0 (the first slot after a bit boundary) is never stretched.
- R4: With code F = `fmod`, the slots 1..ceil(F/2) and 16-floor(F/2)..15 last `presc`+1 source clocks. For example, F=2 stretches slots 1 and 15, and F=15 stretches slots 1 to 15.
- R5: `bit_tick` is high only together with `samp_tick`, on the 16th sample tick of a bit. The slot index then returns to 0.
- R6: The bit index starts at 0 (the start bit) after a restart and wraps after 7. When `smod[index]` is 1, that bit holds 17 sample slots, and the added slot 16 is never stretched.
- R7: `restart` clears the prescale count, the slot index and the bit index. No tick is produced in the restart cycle. The first sample tick then comes in the P-th following cycle, where P is the length of slot 0.
- R8: While `enable` or `os_mode` is 0, no tick or strobe is produced and the counters stay at zero.
- R9: `vote_stb[0]`, `vote_stb[1]` and `vote_stb[2]` mark the sample ticks of slots 7, 8 and 9. At most one is high at a time. One cycle after the slot-9 tick, `vote_bit` holds the majority of `rx_in` at those three ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generator run enable |
| os_mode | input | 1 | 1 selects 16x oversampling operation |
| presc | input | PRESC_W | Integer source clocks per sample slot |
| fmod | input | 4 | First-stage slot stretch code |
| smod | input | BITS | Second-stage per-bit stretch pattern |
| restart | input | 1 | Realign strobe from start-bit detection |
| rx_in | input | 1 | Serial input for majority voting |
| samp_tick | output | 1 | One-cycle 16x sample tick |
| bit_tick | output | 1 | One-cycle bit boundary tick |
| vote_stb | output | 3 | Strobes at sample slots 7, 8, 9 |
| vote_bit | output | 1 | Registered 2-of-3 majority result |

## Verification
A restart can fall in the same cycle as a sample tick that would otherwise be due, and it must win. In bypass mode every running cycle carries a tick, so each reconfiguration in bypass forces this collision. The bench then checks that the restart cycle shows no tick and that the following cycle starts slot 0 again. A bit tick and a vote strobe also share their cycle with a sample tick. Those are judged together on every cycle against a bench model that tracks the slot index, the bit index and the stretch rule.

// File: rtl/ovs_pkg.sv
// Shared constants and the slot stretch rule for the oversampling tick generator.
package ovs_pkg;
    localparam int SLOTS  = 16;
    localparam int SLOT_W = 5;   // holds 0..16, including the added second-stage slot
    localparam int CODE_W = 4;

    // Returns 1 when the given sample slot is one source clock longer under code.
    function automatic logic slot_stretched(input logic [SLOT_W-1:0] slot,
                                            input logic [CODE_W-1:0] code);
        logic [SLOT_W-1:0] lo_end;
        logic [SLOT_W-1:0] hi_start;
        lo_end   = ({1'b0, code} + 5'd1) >> 1;
        hi_start = 5'(SLOTS) - ({1'b0, code} >> 1);
        return ((slot >= 5'd1) && (slot <= lo_end)) ||
               ((slot >= hi_start) && (slot <= 5'(SLOTS - 1)));
    endfunction
endpackage

// File: rtl/ovs_prescaler.sv
// First stage: counts source clocks into sample slots of presc (+1 if stretched).
// Assumes presc is steady between restarts; presc of 0 or 1 means every cycle ticks.
module ovs_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    input  logic               stretch,
    output logic               tick
);
    logic [PRESC_W-1:0] pcnt;
    logic [PRESC_W-1:0] period_m1;
    logic               bypass;

    // Last count value of the current slot.
    always_comb begin
        bypass    = (presc <= PRESC_W'(1));
        period_m1 = presc - PRESC_W'(1) + PRESC_W'(stretch);
    end

    // Tick when the slot is complete; restart always suppresses it.
    assign tick = run && !restart && (bypass || (pcnt >= period_m1));

    // Source-clock counter within the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PRESC_W'(1);
        end
    end
endmodule

// File: rtl/ovs_slot_seq.sv
// Second stage: counts sample ticks into bits, tracks the bit index in the
// character, and applies the per-bit extra slot. Assumes tick is one cycle wide.
module ovs_slot_seq
    import ovs_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] fmod,
    input  logic [BITS-1:0]   smod,
    output logic [SLOT_W-1:0] slot,
    output logic              stretch,
    output logic              bit_tick
);
    localparam int BIDX_W = (BITS > 1) ? $clog2(BITS) : 1;

    logic [BIDX_W-1:0] bidx;
    logic [SLOT_W-1:0] last_slot;

    // Final slot of the current bit, 16 when the bit carries the extra slot.
    always_comb begin
        last_slot = smod[bidx] ? SLOT_W'(SLOTS) : SLOT_W'(SLOTS - 1);
        stretch   = slot_stretched(slot, fmod);
    end

    assign bit_tick = tick && (slot >= last_slot);

    // Slot and bit index advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            slot <= '0;
            bidx <= '0;
        end else if (bit_tick) begin
            slot <= '0;
            bidx <= (bidx == BIDX_W'(BITS - 1)) ? '0 : bidx + BIDX_W'(1);
        end else if (tick) begin
            slot <= slot + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/ovs_vote.sv
// Mid-bit strobes at slots 7, 8, 9 and a registered 2-of-3 vote of the serial input.
module ovs_vote
    import ovs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              rx_in,
    output logic [2:0]        stb,
    output logic              vote
);
    localparam int FIRST = 7;

    logic s_a;
    logic s_b;

    // One strobe per voting slot.
    for (genvar i = 0; i < 3; i++) begin : g_stb
        assign stb[i] = tick && (slot == SLOT_W'(FIRST + i));
    end

    // Capture the first two samples and resolve the vote on the third.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_a  <= 1'b0;
            s_b  <= 1'b0;
            vote <= 1'b0;
        end else begin
            if (stb[0]) s_a <= rx_in;
            if (stb[1]) s_b <= rx_in;
            if (stb[2]) vote <= (s_a & s_b) | (s_a & rx_in) | (s_b & rx_in);
        end
    end
endmodule

// File: rtl/ovs_baud_gen.sv
// Top: two cascaded fractional dividers plus mid-bit voting for 16x oversampling.
// Assumes configuration inputs change only together with restart or while idle.
module ovs_baud_gen
    import ovs_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int BITS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               os_mode,
    input  logic [PRESC_W-1:0] presc,
    input  logic [CODE_W-1:0]  fmod,
    input  logic [BITS-1:0]    smod,
    input  logic               restart,
    input  logic               rx_in,
    output logic               samp_tick,
    output logic               bit_tick,
    output logic [2:0]         vote_stb,
    output logic               vote_bit
);
    logic              run;
    logic              stretch;
    logic [SLOT_W-1:0] slot;

    assign run = enable && os_mode;

    ovs_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .presc(presc), .stretch(stretch), .tick(samp_tick)
    );

    ovs_slot_seq #(.BITS(BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .tick(samp_tick), .fmod(fmod), .smod(smod),
        .slot(slot), .stretch(stretch), .bit_tick(bit_tick)
    );

    ovs_vote u_vote (
        .clk(clk), .rst_n(rst_n), .tick(samp_tick), .slot(slot),
        .rx_in(rx_in), .stb(vote_stb), .vote(vote_bit)
    );
endmodule

// File: rtl/ovs_baud_chk.sv
// Port-level properties of the tick generator, attached to the top by bind.
module ovs_baud_chk #(
    parameter int PRESC_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               os_mode,
    input logic [PRESC_W-1:0] presc,
    input logic               restart,
    input logic               samp_tick,
    input logic               bit_tick,
    input logic [2:0]         vote_stb
);
    assert_bypass_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && os_mode && !restart && presc <= PRESC_W'(1)) |-> samp_tick);

    assert_bit_with_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> samp_tick);

    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !samp_tick);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && os_mode) |-> (!samp_tick && !bit_tick && vote_stb == 3'b000));

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vote_stb));

    assert_strobe_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_stb != 3'b000) |-> samp_tick);

    assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_tick && presc >= PRESC_W'(2) && $stable(presc) && !restart) |=> !samp_tick);
endmodule

bind ovs_baud_gen ovs_baud_chk #(.PRESC_W(PRESC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .os_mode(os_mode),
    .presc(presc), .restart(restart), .samp_tick(samp_tick),
    .bit_tick(bit_tick), .vote_stb(vote_stb)
);

// File: tb/sim_ovs_baud_gen.sv
`timescale 1ns/1ps
module sim_ovs_baud_gen;
    localparam int PW = 16;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          os_mode = 1'b0;
    logic [PW-1:0] presc = '0;
    logic [3:0]    fmod = '0;
    logic [NB-1:0] smod = '0;
    logic          restart = 1'b0;
    logic          rx_in = 1'b0;
    logic          samp_tick;
    logic          bit_tick;
    logic [2:0]    vote_stb;
    logic          vote_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ovs_baud_gen #(.PRESC_W(PW), .BITS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .os_mode(os_mode),
        .presc(presc), .fmod(fmod), .smod(smod), .restart(restart),
        .rx_in(rx_in), .samp_tick(samp_tick), .bit_tick(bit_tick),
        .vote_stb(vote_stb), .vote_bit(vote_bit)
    );

    // Reference stretch rule from R4.
    function automatic bit ref_stretch(input int s, input int f);
        return (s >= 1 && s <= (f + 1) / 2) || (s >= 16 - f / 2 && s <= 15);
    endfunction

    // Reference slot length in source clocks (R2, R3, R4).
    function automatic int ref_period(input int p, input int f, input int s);
        if (p <= 1) return 1;
        return p + (ref_stretch(s, f) ? 1 : 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Idle period: no ticks or strobes while not running (R8).
    task automatic idle_check(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            rx_in = 1'($urandom);
            #1;
            check(!samp_tick && !bit_tick && vote_stb == 3'b000, "R8",
                  {samp_tick, bit_tick, vote_stb}, 0);
        end
    endtask

    // Restart with a configuration, then follow nticks sample ticks against the model.
    task automatic run_cfg(input int p, input int f, input logic [NB-1:0] sm, input int nticks);
        int  s = 0, b = 0, cnt = 0, ticks = 0;
        bit  first = 1, vpend = 0, r7 = 0, r8 = 0, ev = 0;
        @(negedge clk);
        presc = PW'(p); fmod = 4'(f); smod = sm;
        enable = 1'b1; os_mode = 1'b1; restart = 1'b1;
        #1;
        check(!samp_tick, "R7", samp_tick, 0);   // restart wins over a due tick
        while (ticks < nticks) begin
            int  per, last;
            bit  et, eb;
            logic [2:0] es;
            string tag;
            @(negedge clk);
            restart = 1'b0;
            rx_in = 1'($urandom);
            #1;
            cnt++;
            per  = ref_period(p, f, s);
            last = sm[b] ? 16 : 15;
            et   = (cnt == per);
            eb   = et && (s == last);
            es   = et ? ((s == 7) ? 3'b001 : (s == 8) ? 3'b010 : (s == 9) ? 3'b100 : 3'b000) : 3'b000;
            if (first) tag = "R7";
            else if (p <= 1) tag = "R2";
            else if (ref_stretch(s, f)) tag = "R4";
            else tag = "R3";
            check(samp_tick == et, tag, samp_tick, et);
            check(bit_tick == eb, sm[b] ? "R6" : "R5", bit_tick, eb);
            check(vote_stb == es, "R9", vote_stb, es);
            if (vpend) begin
                check(vote_bit == ev, "R9", vote_bit, ev);
                vpend = 0;
            end
            if (et) begin
                if (s == 7) r7 = rx_in;
                if (s == 8) r8 = rx_in;
                if (s == 9) begin
                    ev = (r7 & r8) | (r7 & rx_in) | (r8 & rx_in);
                    vpend = 1;
                end
                first = 0;
                cnt = 0;
                ticks++;
                if (eb) begin s = 0; b = (b + 1) % NB; end
                else s++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0c16));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: quiet outputs after reset
        check(!samp_tick && !bit_tick && vote_stb == 3'b000 && !vote_bit, "R1",
              {samp_tick, bit_tick, vote_stb, vote_bit}, 0);
        // Directed: every code with bypass, minimum and small prescale values.
        for (int f = 0; f < 16; f++) begin
            run_cfg(0, f, 8'h00, 36);
            run_cfg(1, f, 8'h01, 36);
            run_cfg(2, f, 8'h00, 36);
            run_cfg(5, f, NB'($urandom), 36);
        end
        // Long run through all bit indices with full extra-slot pattern (R6).
        run_cfg(3, 9, 8'hFF, 8 * 17 + 20);
        run_cfg(4, 6, 8'hA5, 8 * 17 + 20);
        // R8: disabled and non-oversampling mode produce nothing.
        @(negedge clk); enable = 1'b0;
        idle_check(30);
        @(negedge clk); enable = 1'b1; os_mode = 1'b0; presc = PW'(0);
        idle_check(30);
        // Random configurations.
        for (int k = 0; k < 24; k++) begin
            run_cfg(int'($urandom_range(0, 20)), int'($urandom_range(0, 15)),
                    NB'($urandom), int'($urandom_range(20, 60)));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(5.0 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule